// File: doc/BRIEF.md
# Video Port Pixel Capture Front-End

This block sits at the receiving end of a parallel RGB video port. It samples the port on the pixel clock and turns it into a clean internal pixel stream for a downstream line buffer. Frames are marked with a start-of-frame flag, lines with a start-of-line flag, and each emitted pixel with a valid flag. Configuration inputs choose the active level of the horizontal sync, the vertical sync and the data enable, and how many of the 24 data bits are kept. All three of these choices are independent of each other.

The block has two operating modes. In sync mode, framing comes only from the sync and data-enable levels, and the stall output is held low. In stall mode, the syncs and the data enable are ignored. The block then tells the pixel source when to pause through a registered stall output, which follows the downstream ready signal. It accepts a pixel on each cycle in which the source presented valid while stall was low.

A three-state controller runs the block:
- IDLE: the controller waits for a frame to begin and reloads the configuration on every cycle.
- VIDEO: sync-driven capture.
- STALL: handshake-driven capture.

The transitions are:
- IDLE→VIDEO: on an active vertical sync edge while sync mode is selected.
- IDLE→STALL: on the first accepted pixel while stall mode is selected.
- VIDEO→IDLE: on a vertical sync edge while stall mode is requested.
- STALL→IDLE: as soon as stall mode is cleared.

Top module: `vport_capture`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_sof, out_sol, out_valid and out_stall are 0, out_pix is 0, and the controller is in IDLE with all latched configuration fields at 0.
- R2: Every port input is registered once before any decision. A level presented before clock edge k is reflected on the outputs after edge k+1.
- R3: A start-of-frame edge is a registered vertical sync that differs from its previous registered value and equals the active level. The active level is 1 when cfg_vs_low=0 and 0 when cfg_vs_low=1. In VIDEO, or on IDLE→VIDEO, such an edge sets out_sof for one cycle.
- R4: A start-of-line edge is detected in the same way on the horizontal sync, with cfg_hs_low choosing the active level. It sets out_sol, but only in VIDEO or on the IDLE→VIDEO cycle, and never in stall mode.
- R5: In sync mode, out_valid is 1 for each registered data-enable sample that equals the active level (1 when cfg_de_low=0, 0 when cfg_de_low=1).
- R6: cfg_width selects the bits passed to out_pix: 00 keeps bits 15:0, 01 keeps bits 17:0, and 10 and 11 keep all 24 bits. The bits that are not kept read 0. out_pix is 0 whenever out_valid is 0.
- R7: In VIDEO, changes to the configuration are ignored until the next start-of-frame edge. The new values apply from the cycle after that edge. In IDLE, the configuration is reloaded on every cycle.
- R8: In stall mode, out_stall equals the inverse of dn_ready sampled one edge earlier. A pixel is accepted when in_valid was high in a cycle in which out_stall was low. The sync and data-enable inputs have no effect in this mode.
- R9: In sync mode, out_stall stays 0 and in_valid has no effect.
- R10: IDLE→STALL sets out_sof together with out_valid on the first accepted pixel. A vertical sync edge that arrives while stall mode is requested takes VIDEO→IDLE and emits nothing. Clearing stall mode takes STALL→IDLE on the next edge and emits nothing.
- R11: In IDLE in sync mode, data-enable and horizontal sync activity produce no output until the first start-of-frame edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stall_mode | input | 1 | 1 selects stall-handshake mode, 0 selects sync mode |
| cfg_hs_low | input | 1 | Horizontal sync is active-low when set |
| cfg_vs_low | input | 1 | Vertical sync is active-low when set |
| cfg_de_low | input | 1 | Data enable is active-low when set |
| cfg_width | input | 2 | Captured bus width: 00=16, 01=18, 10/11=24 |
| in_hs | input | 1 | Horizontal sync from the port |
| in_vs | input | 1 | Vertical sync from the port |
| in_de | input | 1 | Data enable from the port |
| in_valid | input | 1 | Source pixel valid, used in stall mode |
| in_data | input | 24 | Parallel pixel data |
| dn_ready | input | 1 | Downstream can take pixels (stall mode) |
| out_stall | output | 1 | Pause request to the pixel source |
| out_sof | output | 1 | Start-of-frame marker |
| out_sol | output | 1 | Start-of-line marker |
| out_valid | output | 1 | Pixel valid |
| out_pix | output | 24 | Width-masked pixel |

## Verification
The bench first drives data-enable bursts and line syncs before any vertical sync. This separates a correct IDLE wait from a block that starts streaming early. It then runs full frames with active-high and then active-low polarities, changing the configuration mid-frame, which shows whether the new settings are held back until the next frame edge. Frames at each width code expose masking errors in bits 16 to 23. A long stretch of random valid and ready levels in stall mode, with random sync noise, checks that acceptance follows the registered stall and that the syncs are ignored. Mode switches in both directions check the silent IDLE transitions.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_VIDEO = 2'd1,
        ST_STALL = 2'd2
    } vcap_state_e;

    typedef struct packed {
        logic       stall_mode;
        logic       hs_low;
        logic       vs_low;
        logic       de_low;
        logic [1:0] width;
    } vcap_cfg_t;

    localparam logic [1:0] WSEL_16 = 2'b00;
    localparam logic [1:0] WSEL_18 = 2'b01;
    localparam int unsigned NARROW_A = 16;
    localparam int unsigned NARROW_B = 18;

endpackage

// File: rtl/vcap_sync_in.sv
`timescale 1ns/1ps
module vcap_sync_in #(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic              in_de,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              stall_now,
    output logic              r_hs,
    output logic              r_vs,
    output logic              r_de,
    output logic              r_valid,
    output logic              r_stall,
    output logic [DATA_W-1:0] r_data,
    output logic              p_hs,
    output logic              p_vs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_hs    <= 1'b0;
            r_vs    <= 1'b0;
            r_de    <= 1'b0;
            r_valid <= 1'b0;
            r_stall <= 1'b0;
            r_data  <= '0;
            p_hs    <= 1'b0;
            p_vs    <= 1'b0;
        end else begin
            r_hs    <= in_hs;
            r_vs    <= in_vs;
            r_de    <= in_de;
            r_valid <= in_valid;
            r_stall <= stall_now;
            r_data  <= in_data;
            p_hs    <= r_hs;
            p_vs    <= r_vs;
        end
    end

endmodule

// File: rtl/vcap_ctrl.sv
`timescale 1ns/1ps
module vcap_ctrl
    import vcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  vcap_cfg_t   cfg,
    input  logic        r_hs,
    input  logic        r_vs,
    input  logic        r_de,
    input  logic        r_valid,
    input  logic        r_stall,
    input  logic        p_hs,
    input  logic        p_vs,
    input  logic        dn_ready,
    output vcap_state_e state,
    output logic [1:0]  act_width,
    output logic        emit_sof,
    output logic        emit_sol,
    output logic        emit_pix,
    output logic        out_stall
);

    vcap_state_e state_d;
    vcap_cfg_t   act, act_d;
    logic        load;
    logic        vs_edge, hs_edge, de_on, accept;

    // Edge = raw level changed and now sits at the active level
    always_comb begin
        vs_edge = (r_vs != p_vs) && (r_vs != act.vs_low);
        hs_edge = (r_hs != p_hs) && (r_hs != act.hs_low);
        de_on   = r_de ^ act.de_low;
        accept  = r_valid & ~r_stall;
    end

    // Next state and emit decisions
    always_comb begin
        state_d  = state;
        load     = 1'b0;
        emit_sof = 1'b0;
        emit_sol = 1'b0;
        emit_pix = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load = 1'b1;
                if (!act.stall_mode && !cfg.stall_mode && vs_edge) begin
                    state_d  = ST_VIDEO;
                    emit_sof = 1'b1;
                    emit_sol = hs_edge;
                    emit_pix = de_on;
                end else if (act.stall_mode && cfg.stall_mode && accept) begin
                    state_d  = ST_STALL;
                    emit_sof = 1'b1;
                    emit_pix = 1'b1;
                end
            end
            ST_VIDEO: begin
                if (vs_edge) begin
                    load = 1'b1;
                    if (cfg.stall_mode) begin
                        state_d = ST_IDLE;
                    end else begin
                        emit_sof = 1'b1;
                        emit_sol = hs_edge;
                        emit_pix = de_on;
                    end
                end else begin
                    emit_sol = hs_edge;
                    emit_pix = de_on;
                end
            end
            ST_STALL: begin
                if (!cfg.stall_mode) begin
                    load    = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    emit_pix = accept;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        act_d = load ? cfg : act;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Latched configuration and stall output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act       <= '0;
            out_stall <= 1'b0;
        end else begin
            act       <= act_d;
            out_stall <= act_d.stall_mode & ~dn_ready;
        end
    end

    assign act_width = act.width;

    // R9
    video_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_VIDEO |-> !out_stall);

    // R8
    stall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STALL |-> out_stall == !$past(dn_ready));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VIDEO && $past(state) == ST_VIDEO && !$past(vs_edge))
        |-> act == $past(act));

endmodule

// File: rtl/vcap_emit.sv
`timescale 1ns/1ps
module vcap_emit
    import vcap_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_sof,
    input  logic              emit_sol,
    input  logic              emit_pix,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        width,
    output logic              out_sof,
    output logic              out_sol,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_pix
);

    logic [DATA_W-1:0] mask;
    int unsigned       keep;

    always_comb begin
        if (width == WSEL_16)      keep = NARROW_A;
        else if (width == WSEL_18) keep = NARROW_B;
        else                       keep = DATA_W;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            mask[i] = (i < keep);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_sof   <= emit_sof;
            out_sol   <= emit_sol;
            out_valid <= emit_pix;
            out_pix   <= emit_pix ? (data & mask) : '0;
        end
    end

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_pix == '0);

    // R6
    narrow16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(width) == WSEL_16) |-> out_pix[DATA_W-1:NARROW_A] == '0);

    // R6
    narrow18_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(width) == WSEL_18) |-> out_pix[DATA_W-1:NARROW_B] == '0);

endmodule

// File: rtl/vport_capture.sv
`timescale 1ns/1ps
module vport_capture
    import vcap_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stall_mode,
    input  logic              cfg_hs_low,
    input  logic              cfg_vs_low,
    input  logic              cfg_de_low,
    input  logic [1:0]        cfg_width,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic              in_de,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dn_ready,
    output logic              out_stall,
    output logic              out_sof,
    output logic              out_sol,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_pix
);

    vcap_cfg_t         cfg;
    vcap_state_e       state;
    logic              r_hs, r_vs, r_de, r_valid, r_stall, p_hs, p_vs;
    logic [DATA_W-1:0] r_data;
    logic [1:0]        act_width;
    logic              emit_sof, emit_sol, emit_pix;

    assign cfg = '{stall_mode: cfg_stall_mode, hs_low: cfg_hs_low,
                   vs_low: cfg_vs_low, de_low: cfg_de_low, width: cfg_width};

    vcap_sync_in #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .in_valid(in_valid),
        .in_data(in_data), .stall_now(out_stall),
        .r_hs(r_hs), .r_vs(r_vs), .r_de(r_de), .r_valid(r_valid),
        .r_stall(r_stall), .r_data(r_data), .p_hs(p_hs), .p_vs(p_vs)
    );

    vcap_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .r_hs(r_hs), .r_vs(r_vs), .r_de(r_de), .r_valid(r_valid),
        .r_stall(r_stall), .p_hs(p_hs), .p_vs(p_vs), .dn_ready(dn_ready),
        .state(state), .act_width(act_width),
        .emit_sof(emit_sof), .emit_sol(emit_sol), .emit_pix(emit_pix),
        .out_stall(out_stall)
    );

    vcap_emit #(.DATA_W(DATA_W)) u_emit (
        .clk(clk), .rst_n(rst_n),
        .emit_sof(emit_sof), .emit_sol(emit_sol), .emit_pix(emit_pix),
        .data(r_data), .width(act_width),
        .out_sof(out_sof), .out_sol(out_sol), .out_valid(out_valid),
        .out_pix(out_pix)
    );

    // R3
    sof_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> state != ST_IDLE);

    // R10
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && $past(state) == ST_IDLE) |-> (out_sof && out_valid));

    // R4
    no_sol_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && $past(state) == ST_STALL) |-> !out_sol);

endmodule

// File: tb/vport_capture_tb.sv
`timescale 1ns/1ps
module vport_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_stall_mode = 1'b0, cfg_hs_low = 1'b0, cfg_vs_low = 1'b0, cfg_de_low = 1'b0;
    logic [1:0]  cfg_width = 2'b10;
    logic        in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0, in_valid = 1'b0, dn_ready = 1'b1;
    logic [23:0] in_data = '0;
    logic        out_stall, out_sof, out_sol, out_valid;
    logic [23:0] out_pix;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    bit    checking = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    vport_capture u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_stall_mode(cfg_stall_mode), .cfg_hs_low(cfg_hs_low),
        .cfg_vs_low(cfg_vs_low), .cfg_de_low(cfg_de_low), .cfg_width(cfg_width),
        .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .in_valid(in_valid),
        .in_data(in_data), .dn_ready(dn_ready),
        .out_stall(out_stall), .out_sof(out_sof), .out_sol(out_sol),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // Behavioural reference: two-entry input history, mode number, latched settings
    typedef struct {
        logic hs, vs, de, val, stl;
        logic [23:0] dat;
    } sample_t;

    sample_t     hist[$];
    int          mode;        // 0 waiting, 1 sync capture, 2 handshake capture
    logic        k_sm, k_hl, k_vl, k_dl;
    logic [1:0]  k_w;
    logic        x_sof, x_sol, x_val, x_stall;
    logic [23:0] x_pix;

    function automatic void model_reset();
        sample_t z;
        z = '{hs: 1'b0, vs: 1'b0, de: 1'b0, val: 1'b0, stl: 1'b0, dat: 24'h0};
        hist = {z, z};
        mode = 0;
        {k_sm, k_hl, k_vl, k_dl} = 4'b0;
        k_w = 2'b00;
        {x_sof, x_sol, x_val, x_stall} = 4'b0;
        x_pix = '0;
    endfunction

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            sample_t cur, prv, nw;
            bit vse, hse, den, acc, ld, s, l, p;
            int nm, keep;
            cur = hist[0];
            prv = hist[1];
            vse = (cur.vs != prv.vs) && (cur.vs == !k_vl);
            hse = (cur.hs != prv.hs) && (cur.hs == !k_hl);
            den = (cur.de == !k_dl);
            acc = cur.val && !cur.stl;
            nm = mode; ld = 0; s = 0; l = 0; p = 0;
            if (mode == 0) begin
                ld = 1;
                if (!k_sm && !cfg_stall_mode && vse) begin nm = 1; s = 1; l = hse; p = den; end
                else if (k_sm && cfg_stall_mode && acc) begin nm = 2; s = 1; p = 1; end
            end else if (mode == 1) begin
                if (vse) begin
                    ld = 1;
                    if (cfg_stall_mode) nm = 0;
                    else begin s = 1; l = hse; p = den; end
                end else begin
                    l = hse; p = den;
                end
            end else begin
                if (!cfg_stall_mode) begin ld = 1; nm = 0; end
                else p = acc;
            end
            keep = (k_w == 2'b00) ? 16 : (k_w == 2'b01) ? 18 : 24;
            x_sof = s; x_sol = l; x_val = p;
            x_pix = p ? (cur.dat & 24'(((33'h1 << keep) - 1))) : 24'h0;
            mode = nm;
            if (ld) begin
                k_sm = cfg_stall_mode; k_hl = cfg_hs_low; k_vl = cfg_vs_low;
                k_dl = cfg_de_low; k_w = cfg_width;
            end
            nw = '{hs: in_hs, vs: in_vs, de: in_de, val: in_valid, stl: x_stall, dat: in_data};
            hist.push_front(nw);
            void'(hist.pop_back());
            x_stall = k_sm && !dn_ready;
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (checking && !done) begin
            vectors++;
            if (out_sof !== x_sof) begin
                miscompares++;
                $display("FAIL %s out_sof act=%0b exp=%0b t=%0t", cur_req, out_sof, x_sof, $time);
            end
            if (out_sol !== x_sol) begin
                miscompares++;
                $display("FAIL %s out_sol act=%0b exp=%0b t=%0t", cur_req, out_sol, x_sol, $time);
            end
            if (out_valid !== x_val) begin
                miscompares++;
                $display("FAIL %s out_valid act=%0b exp=%0b t=%0t", cur_req, out_valid, x_val, $time);
            end
            if (out_pix !== x_pix) begin
                miscompares++;
                $display("FAIL %s out_pix act=%h exp=%h t=%0t", cur_req, out_pix, x_pix, $time);
            end
            if (out_stall !== x_stall) begin
                miscompares++;
                $display("FAIL %s out_stall act=%0b exp=%0b t=%0t", cur_req, out_stall, x_stall, $time);
            end
        end
    end

    task automatic cyc(input logic hs, input logic vs, input logic de,
                       input logic val, input logic rdy);
        in_hs    = hs ^ cfg_hs_low;
        in_vs    = vs ^ cfg_vs_low;
        in_de    = de ^ cfg_de_low;
        in_valid = val;
        dn_ready = rdy;
        in_data  = 24'($urandom);
        @(negedge clk);
    endtask

    task automatic line(input int n);
        repeat (2) cyc(1, 0, 0, 0, 1);
        repeat (2) cyc(0, 0, 0, 0, 1);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 1);
        repeat (2) cyc(0, 0, 0, 0, 1);
    endtask

    task automatic frame(input int nl, input int n);
        repeat (2) cyc(0, 1, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        for (int i = 0; i < nl; i++) line(n);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
    end

    initial begin
        // R1: reset values
        cur_req = "R1";
        @(negedge clk);
        checking = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) cyc(0, 0, 0, 0, 1);

        // R11: data enable and line syncs before any frame edge
        cur_req = "R11";
        line(4);
        line(3);

        // R3: frames with active-high syncs, full width
        cur_req = "R3";
        frame(3, 6);

        // R7: settings changed mid-frame wait for the next frame edge
        cur_req = "R7";
        cfg_de_low = 1'b1;
        cfg_width  = 2'b00;
        line(5);
        frame(2, 5);

        // R5: active-low data enable in its own frame
        cur_req = "R5";
        frame(2, 4);

        // R4: active-low line and frame syncs, 18-bit capture
        cur_req = "R4";
        cfg_hs_low = 1'b1;
        cfg_vs_low = 1'b1;
        cfg_width  = 2'b01;
        frame(2, 7);
        frame(2, 7);

        // R6: reserved width code and 16-bit capture
        cur_req = "R6";
        cfg_width = 2'b11;
        frame(2, 4);
        cfg_width = 2'b00;
        frame(2, 4);

        // R9: source valid and ready toggling in sync mode
        cur_req = "R9";
        for (int i = 0; i < 20; i++) cyc(0, 0, i % 3 == 0, i % 2 == 0, i % 4 != 0);
        frame(1, 5);

        // R2: random sync noise in sync mode
        cur_req = "R2";
        for (int i = 0; i < 300; i++)
            cyc(1'($urandom), ($urandom % 16) == 0, 1'($urandom), 1'($urandom), 1'($urandom));

        // R10: frame edge with stall requested -> silent return to waiting
        cur_req = "R10";
        cfg_stall_mode = 1'b1;
        cfg_width = 2'b10;
        frame(1, 3);

        // R8: handshake capture with random valid/ready and sync noise
        cur_req = "R8";
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 4) != 0, ($urandom % 3) != 0);

        // R10: leaving handshake mode, then back into sync frames
        cur_req = "R10";
        cfg_stall_mode = 1'b0;
        repeat (5) cyc(0, 0, 0, 1, 0);
        frame(2, 4);
        cfg_stall_mode = 1'b1;
        cfg_width = 2'b01;
        frame(1, 2);
        for (int i = 0; i < 100; i++) cyc(0, 0, 0, 1'($urandom), 1'($urandom));

        repeat (4) cyc(0, 0, 0, 0, 1);
        finish_run();
    end

endmodule